// File: doc/BRIEF.md
# Sticky Interrupt Request Flag Register

This block holds eight bits of interrupt request state that software reaches over a simple synchronous register bus. Seven of the bits are sticky flags. A timer overflow pulse sets one, a serial transfer-complete pulse sets another, and edges on five external request pins set the remaining five. The eighth position is reserved and always reads back as one.

Each request pin first passes through a synchronizer and then an edge detector. The edge detector looks for a rising or a falling edge, chosen per pin, and it reports an edge only while that pin is set up to act as an interrupt input.

Taking an interrupt does not clear its flag. Software clears a flag by writing a zero to its bit position; a one written to any position changes nothing. When hardware sets a flag in the same cycle that software tries to clear it, the set wins, so no event is lost. A per-bit enable mask selects which flags drive the single interrupt output.

Top module: `irq_flag_reg`

## Requirements
- R1: The bit layout is fixed: bit 7 is the timer flag, bit 6 is the serial flag, bit 5 is reserved, and bits 4..0 are the flags for request pins 4..0, one bit per pin at the same index.
- R2: After reset all seven flags are 0, a read returns 0x20, and the interrupt output is low.
- R3: Bit 5 reads as 1 on every read that selects the register, and writing it, with either value, has no effect.
- R4: A write that selects the register clears every flag whose write-data bit is 0. The clear takes effect on the clock edge of the write.
- R5: A write-data bit of 1 leaves the matching flag unchanged, whether that flag is 0 or 1.
- R6: A one-cycle timer overflow pulse sets bit 7 on the clock edge where the pulse is sampled.
- R7: A one-cycle serial done pulse sets bit 6 on the clock edge where the pulse is sampled.
- R8: While pin n's mode input is 1, an edge on that pin sets bit n. The edge select picks the edge: 1 means rising, 0 means falling. The flag becomes 1 on the third rising clock edge after the pin changes.
- R9: While pin n's mode input is 0, no transition on that pin sets bit n.
- R10: When a hardware set event and a write of 0 reach the same flag in the same cycle, the flag is 1 afterwards.
- R11: A flag stays 1 through any number of cycles until a write of 0 clears it. Nothing clears it automatically.
- R12: The interrupt output is 1 exactly when some flag other than bit 5 is 1 and its enable-mask bit is 1. Mask bit 5 is ignored.
- R13: When the address does not match the register address, the read data is 0x00 and a write has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data; a 0 clears the flag at that bit |
| bus_rdata | output | 8 | Read data, combinational from the address |
| tmr_ovf_pulse | input | 1 | One-cycle timer wrap event |
| ser_done_pulse | input | 1 | One-cycle serial transfer-complete event |
| irq_pin | input | 5 | Raw external request pins (asynchronous) |
| pin_irq_mode | input | 5 | Per-pin interrupt-input enable |
| pin_rise_sel | input | 5 | Per-pin edge select: 1 rising, 0 falling |
| flag_en | input | 8 | Per-flag interrupt enable mask; bit 5 ignored |
| irq_out | output | 1 | OR of the enabled flags |

## Verification
The hardest case to reach from the ports is a hardware set that lands in exactly the same cycle as a software clear of the same flag. Pin events pass through a three-cycle path, so they cannot easily be aligned with a write. The directed stimulus therefore uses the single-cycle serial and timer pulses, driven alongside an all-zero write. A long random phase then mixes pulses with random writes, random addresses and random masks. In that phase the pin modes are off while the pins toggle, which checks that pin edges are gated on every cycle.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
   localparam int REG_W   = 8;
   localparam int TMR_BIT = 7;
   localparam int SER_BIT = 6;
   localparam int RSV_BIT = 5;
   localparam int NUM_IRQ = 5;
   localparam logic [REG_W-1:0] RSV_MASK = REG_W'(1) << RSV_BIT;
   localparam logic [REG_W-1:0] IRQ_MASK = ~RSV_MASK;
endpackage

// File: rtl/irqf_pin_edge.sv
module irqf_pin_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic mode_en,
   input  logic rise_sel,
   output logic edge_hit
);
   localparam int TOP = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [TOP:0] sync_q;
   logic         prev_q;
   logic         lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[TOP-1:0], pin};
         prev_q <= sync_q[TOP];
      end
   end

   assign lvl = sync_q[TOP];

   always_comb begin
      if (!mode_en)
         edge_hit = 1'b0;
      else if (rise_sel)
         edge_hit = lvl & ~prev_q;
      else
         edge_hit = ~lvl & prev_q;
   end
endmodule

// File: rtl/irqf_flag_cell.sv
module irqf_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_req,
   output logic flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set_evt)
         flag_q <= 1'b1;
      else if (clr_req)
         flag_q <= 1'b0;
   end

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag_q);
   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_evt) |=> !flag_q);
   assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr_req) |=> flag_q);
   assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && !set_evt) |=> !flag_q);
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
   parameter int               ADDR_W      = 4,
   parameter logic [ADDR_W-1:0] REG_ADDR   = 4'h3,
   parameter int               SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              tmr_ovf_pulse,
   input  logic              ser_done_pulse,
   input  logic [4:0]        irq_pin,
   input  logic [4:0]        pin_irq_mode,
   input  logic [4:0]        pin_rise_sel,
   input  logic [7:0]        flag_en,
   output logic              irq_out
);
   import irqf_pkg::*;

   generate
      if (REG_W != 8 || NUM_IRQ != 5 || RSV_BIT <= NUM_IRQ - 1) begin : g_bad_layout
         $error("register layout parameters are inconsistent");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be positive");
      end
   endgenerate

   logic             sel_hit;
   logic             wr_hit;
   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] clr_vec;
   logic [REG_W-1:0] flag_q;
   logic [NUM_IRQ-1:0] pin_edge;
   logic             rsv_unused;

   assign sel_hit = (bus_addr == REG_ADDR);
   assign wr_hit  = sel_hit & bus_wr;
   assign clr_vec = {REG_W{wr_hit}} & ~bus_wdata;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_IRQ; gi++) begin : g_pin
         irqf_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (irq_pin[gi]),
            .mode_en  (pin_irq_mode[gi]),
            .rise_sel (pin_rise_sel[gi]),
            .edge_hit (pin_edge[gi])
         );

         assert_mode_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!pin_irq_mode[gi] && !flag_q[gi]) |=> !flag_q[gi]);
      end
   endgenerate

   always_comb begin
      set_vec                 = '0;
      set_vec[NUM_IRQ-1:0]    = pin_edge;
      set_vec[TMR_BIT]        = tmr_ovf_pulse;
      set_vec[SER_BIT]        = ser_done_pulse;
   end

   generate
      for (gi = 0; gi < REG_W; gi++) begin : g_bit
         if (gi == RSV_BIT) begin : g_rsv
            assign flag_q[gi] = 1'b1;
         end else begin : g_flag
            irqf_flag_cell u_cell (
               .clk     (clk),
               .rst_n   (rst_n),
               .set_evt (set_vec[gi]),
               .clr_req (clr_vec[gi]),
               .flag_q  (flag_q[gi])
            );
         end
      end
   endgenerate

   assign rsv_unused = set_vec[RSV_BIT] ^ clr_vec[RSV_BIT];

   assign bus_rdata = sel_hit ? flag_q : '0;
   assign irq_out   = |(flag_q & flag_en & IRQ_MASK);

   assert_reserved_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_hit |-> bus_rdata[RSV_BIT]);
   assert_timer_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf_pulse |=> (sel_hit -> bus_rdata[TMR_BIT]) && flag_q[TMR_BIT]);
   assert_irq_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en[4:0] == 5'b0 && flag_en[7:6] == 2'b0) |-> !irq_out);
endmodule

// File: tb/irq_flag_reg_tb.sv
module irq_flag_reg_tb;
   localparam logic [3:0] RA = 4'h3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       tmr_ovf_pulse = 1'b0;
   logic       ser_done_pulse = 1'b0;
   logic [4:0] irq_pin = '0;
   logic [4:0] pin_irq_mode = '0;
   logic [4:0] pin_rise_sel = '0;
   logic [7:0] flag_en = '0;
   logic       irq_out;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] mf = '0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_flag_reg u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tmr_ovf_pulse(tmr_ovf_pulse), .ser_done_pulse(ser_done_pulse),
      .irq_pin(irq_pin), .pin_irq_mode(pin_irq_mode),
      .pin_rise_sel(pin_rise_sel), .flag_en(flag_en), .irq_out(irq_out)
   );

   function automatic logic [7:0] exp_rd(logic [7:0] f, logic [3:0] a);
      return (a == RA) ? (f | 8'h20) : 8'h00;
   endfunction

   function automatic logic exp_irq(logic [7:0] f, logic [7:0] en);
      return |(f & en & 8'hDF);
   endfunction

   function automatic logic [7:0] next_flags(logic [7:0] f, logic t, logic s,
                                             logic w, logic [3:0] a, logic [7:0] d);
      logic [7:0] setv = {t, s, 6'b0};
      logic [7:0] clrv = (w && a == RA) ? ~d : 8'h00;
      return (setv | (f & ~clrv)) & 8'hDF;
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cycle(input logic t, input logic s, input logic w,
                        input logic [3:0] a, input logic [7:0] d, input string tag);
      @(negedge clk);
      tmr_ovf_pulse = t; ser_done_pulse = s; bus_wr = w; bus_addr = a; bus_wdata = d;
      #1;
      chk(bus_rdata, exp_rd(mf, a), tag);
      chk({7'b0, irq_out}, {7'b0, exp_irq(mf, flag_en)}, tag);
      mf = next_flags(mf, t, s, w, a, d);
   endtask

   task automatic idle(input string tag);
      cycle(1'b0, 1'b0, 1'b0, RA, 8'h00, tag);
   endtask

   task automatic pin_move(input int n, input logic v, input logic expect_set, input string tag);
      @(negedge clk);
      tmr_ovf_pulse = 0; ser_done_pulse = 0; bus_wr = 0; bus_addr = RA;
      irq_pin[n] = v;
      repeat (4) @(negedge clk);
      if (expect_set) mf[n] = 1'b1;
      idle(tag);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2: reset state
      idle("R2");
      // R3 R5: writing ones changes nothing, bit 5 stays 1
      cycle(0, 0, 1, RA, 8'hFF, "R5");
      idle("R3");
      // R6 R7 R1: pulses set bits 7 and 6
      cycle(1, 0, 0, RA, 8'h00, "R6");
      idle("R6");
      cycle(0, 1, 0, RA, 8'h00, "R7");
      repeat (5) idle("R11");
      // R4: clear bit 7 only
      cycle(0, 0, 1, RA, 8'h7F, "R4");
      idle("R4");
      // R10: serial set collides with write of 0
      cycle(0, 1, 1, RA, 8'h00, "R10");
      idle("R10");
      // R13: other address ignored, read data zero
      cycle(0, 0, 1, 4'h5, 8'h00, "R13");
      idle("R13");
      cycle(0, 0, 1, RA, 8'h00, "R4");
      // R8: rising on pin 2
      pin_irq_mode = 5'b00101; pin_rise_sel = 5'b00100;
      pin_move(2, 1'b1, 1'b1, "R8");
      // R8: falling on pin 0, rising edge ignored
      pin_move(0, 1'b1, 1'b0, "R8");
      pin_move(0, 1'b0, 1'b1, "R8");
      // R9: pin 4 disabled
      pin_move(4, 1'b1, 1'b0, "R9");
      pin_move(4, 1'b0, 1'b0, "R9");
      // R12: mask
      flag_en = 8'h20; idle("R12");
      flag_en = 8'h04; idle("R12");
      flag_en = 8'h02; idle("R12");
      cycle(0, 0, 1, RA, 8'h00, "R4");
      // random phase, pins toggling with modes off
      pin_irq_mode = '0;
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] a;
         a = ($urandom % 4 == 0) ? 4'($urandom) : RA;
         irq_pin = 5'($urandom);
         pin_rise_sel = 5'($urandom);
         if (i % 16 == 0) flag_en = 8'($urandom);
         cycle(($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
               a, 8'($urandom), "R9");
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule